// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies a signed matrix A of ROWS rows by DEPTH inner elements with a signed matrix B of DEPTH inner elements by COLS columns. The work is spread over a ROWS × COLS grid of multiply-accumulate cells. Each cell keeps its own running sum. Row r of A sits in a small operand memory on the left edge of grid row r. Column c of B sits in its own operand memory above grid column c. A per-lane index counter walks each memory. Each read fills a boundary register. From there the operands travel right and down through one register per cell. Lanes start one step later per row and per column, so that matching inner elements meet in the right cell.

Software-side logic first fills the operand memories through a simple write port. It then pulses `start`. The block clears every accumulator, every index counter and every boundary register, and runs a fixed number of steps. Every sum is then copied in one cycle into a flat result memory in row-major order, and `done` is raised for one cycle. Results stay readable through a combinational read port until the next run overwrites them.

Top module: `systolic_mm`

## Requirements
- R1: The parameters TOP_DEPTH and LEFT_DEPTH must be equal, and elaboration stops with an error otherwise. Every one of the DEPTH inner terms, including the last (k = DEPTH-1), contributes to each result.
- R2: When `ldEn` is high at a clock edge, `ldData` is written to element `ldAddr` (the inner index k) of one operand memory. With `ldSide` = 0 the target is the left memory of grid row `ldLane` (A[lane][k]). With `ldSide` = 1 the target is the top memory of grid column `ldLane` (B[k][lane]).
- R3: After a run, result address r*COLS + c holds the full-precision signed sum over k of A[r][k]*B[k][c]. Operands are W-bit two's complement, and results are ACC_W = 2*W + clog2(DEPTH) bits wide.
- R4: `start` is accepted only while the block is idle. A `start` pulse during a run neither restarts it nor shifts the time at which `done` is raised.
- R5: `done` is high for exactly one cycle. It is first seen high after the D+ROWS+COLS-th rising edge, counting the edge that samples `start` as edge 0.
- R6: Each accepted `start` clears all accumulators, so the results of a run never include terms from an earlier run.
- R7: Reset clears the result memory to zero and drives `done` low. The result memory changes only in the single copy that makes `done` rise. Writes to the operand memories while idle leave it unchanged.
- R8: The operand memories keep their contents across runs, so a second start without reloading gives the same results.
- R9: `resData` shows the result-memory entry selected by `resAddr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication run (accepted when idle) |
| done | output | 1 | One-cycle pulse when the result memory has been updated |
| ldEn | input | 1 | Operand memory write enable |
| ldSide | input | 1 | 0 = left (A row) memory, 1 = top (B column) memory |
| ldLane | input | LANE_W | Row or column number of the target memory |
| ldAddr | input | MEM_AW | Inner index k of the element written |
| ldData | input | W | Signed operand value |
| resAddr | input | OUT_AW | Result memory read address, r*COLS + c |
| resData | output | ACC_W | Signed result at `resAddr` |

## Verification
The bench goes after the inner-index alignment in three ways. It uses one pattern where only the last inner element is nonzero. A lane whose skew or index counter is off by one would drop or misplace exactly that term. It uses alternating -128/127 operands, which show up a truncated or zero-extended product in the largest sums. The bench also starts a second run without clearing inputs, and fires `start` in the middle of a run. A design that kept stale sums would double the second results. A design that honoured a mid-run start would move `done` away from the cycle the reference model predicts on every clock. The bench also rewrites the operand memories after a run and rereads the results. This catches a result memory that tracks live accumulators instead of holding the copied values.

// File: rtl/systolic_mm_pkg.sv
package systolic_mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WRITE,
    ST_FIN
  } mmState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // start accepted: zero sums, counters, boundary regs
    logic step;      // one compute / operand-shift step
    logic writeOut;  // copy all sums into the result memory
  } mmStrobe_t;

endpackage

// File: rtl/systolic_mm_ctrl.sv
module systolic_mm_ctrl
  import systolic_mm_pkg::*;
#(
  parameter int LAST_STEP = 10,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output mmStrobe_t         stb,
  output logic [STEP_W-1:0] stepCnt,
  output logic              done
);

  mmState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          if (stepCnt == STEP_W'(LAST_STEP)) state <= ST_WRITE;
          else stepCnt <= stepCnt + 1'b1;
        end
        ST_WRITE: state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.clear    = (state == ST_IDLE) && start;
    stb.step     = (state == ST_RUN);
    stb.writeOut = (state == ST_WRITE);
    done         = (state == ST_FIN);
  end

endmodule

// File: rtl/systolic_mm_lane.sv
module systolic_mm_lane #(
  parameter int DEPTH  = 5,
  parameter int W      = 8,
  parameter int MEM_AW = 3,
  parameter int IDX_W  = 3,
  parameter int STEP_W = 4,
  parameter int OFFSET = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                step,
  input  logic [STEP_W-1:0]   stepCnt,
  input  logic                wrEn,
  input  logic [MEM_AW-1:0]   wrAddr,
  input  logic signed [W-1:0] wrData,
  output logic signed [W-1:0] bnd
);

  logic signed [W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]    idx;
  logic                active;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // lane begins OFFSET steps late and stops after DEPTH reads
  assign active = (stepCnt >= STEP_W'(OFFSET)) && (idx != IDX_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
      bnd <= '0;
    end else if (clear) begin
      idx <= '0;
      bnd <= '0;
    end else if (step) begin
      if (active) begin
        bnd <= mem[idx[MEM_AW-1:0]];
        idx <= idx + 1'b1;
      end else begin
        bnd <= '0;
      end
    end
  end

endmodule

// File: rtl/systolic_mm_pe.sv
module systolic_mm_pe #(
  parameter int W         = 8,
  parameter int ACC_W     = 19,
  parameter bit HAS_RIGHT = 1'b1,
  parameter bit HAS_DOWN  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    step,
  input  logic signed [W-1:0]     aIn,
  input  logic signed [W-1:0]     bIn,
  output logic signed [W-1:0]     aOut,
  output logic signed [W-1:0]     bOut,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [2*W-1:0] prod;
  assign prod = aIn * bIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= acc + ACC_W'(prod);
  end

  if (HAS_RIGHT) begin : g_right
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      aOut <= '0;
      else if (clear) aOut <= '0;
      else if (step)  aOut <= aIn;
    end
  end else begin : g_noRight
    assign aOut = '0;
  end

  if (HAS_DOWN) begin : g_down
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      bOut <= '0;
      else if (clear) bOut <= '0;
      else if (step)  bOut <= bIn;
    end
  end else begin : g_noDown
    assign bOut = '0;
  end

endmodule

// File: rtl/systolic_mm_datapath.sv
module systolic_mm_datapath
  import systolic_mm_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int COLS   = 4,
  parameter int DEPTH  = 5,
  parameter int W      = 8,
  parameter int ACC_W  = 19,
  parameter int MEM_AW = 3,
  parameter int IDX_W  = 3,
  parameter int STEP_W = 4,
  parameter int LANE_W = 2,
  parameter int OUT_AW = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mmStrobe_t               stb,
  input  logic [STEP_W-1:0]       stepCnt,
  input  logic                    ldEn,
  input  logic                    ldSide,
  input  logic [LANE_W-1:0]       ldLane,
  input  logic [MEM_AW-1:0]       ldAddr,
  input  logic signed [W-1:0]     ldData,
  input  logic [OUT_AW-1:0]       resAddr,
  output logic signed [ACC_W-1:0] resData
);

  localparam int CELLS = ROWS * COLS;

  logic signed [W-1:0]     aLink [ROWS][COLS+1];
  logic signed [W-1:0]     bLink [ROWS+1][COLS];
  logic signed [ACC_W-1:0] accAll [CELLS];
  logic signed [ACC_W-1:0] outMem [CELLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_left
    systolic_mm_lane #(
      .DEPTH(DEPTH), .W(W), .MEM_AW(MEM_AW), .IDX_W(IDX_W),
      .STEP_W(STEP_W), .OFFSET(r)
    ) lane_i (
      .clk(clk), .rstN(rstN), .clear(stb.clear), .step(stb.step),
      .stepCnt(stepCnt),
      .wrEn(ldEn && !ldSide && (ldLane == LANE_W'(r))),
      .wrAddr(ldAddr), .wrData(ldData),
      .bnd(aLink[r][0])
    );
  end

  for (genvar c = 0; c < COLS; c++) begin : g_top
    systolic_mm_lane #(
      .DEPTH(DEPTH), .W(W), .MEM_AW(MEM_AW), .IDX_W(IDX_W),
      .STEP_W(STEP_W), .OFFSET(c)
    ) lane_i (
      .clk(clk), .rstN(rstN), .clear(stb.clear), .step(stb.step),
      .stepCnt(stepCnt),
      .wrEn(ldEn && ldSide && (ldLane == LANE_W'(c))),
      .wrAddr(ldAddr), .wrData(ldData),
      .bnd(bLink[0][c])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      systolic_mm_pe #(
        .W(W), .ACC_W(ACC_W),
        .HAS_RIGHT(c != COLS - 1), .HAS_DOWN(r != ROWS - 1)
      ) pe_i (
        .clk(clk), .rstN(rstN), .clear(stb.clear), .step(stb.step),
        .aIn(aLink[r][c]), .bIn(bLink[r][c]),
        .aOut(aLink[r][c+1]), .bOut(bLink[r+1][c]),
        .acc(accAll[r*COLS + c])
      );
    end
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             outMem[i] <= '0;
      else if (stb.writeOut) outMem[i] <= accAll[i];
    end
  end

  assign resData = outMem[resAddr];

endmodule

// File: rtl/systolic_mm.sv
module systolic_mm
  import systolic_mm_pkg::*;
#(
  parameter int ROWS       = 3,
  parameter int COLS       = 4,
  parameter int TOP_DEPTH  = 5,
  parameter int LEFT_DEPTH = 5,
  parameter int W          = 8,
  localparam int DEPTH     = TOP_DEPTH,
  localparam int ACC_W     = 2 * W + $clog2(DEPTH),
  localparam int MEM_AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IDX_W     = $clog2(DEPTH + 1),
  localparam int LAST_STEP = DEPTH + ROWS + COLS - 2,
  localparam int STEP_W    = $clog2(LAST_STEP + 1),
  localparam int MAX_LANES = (ROWS > COLS) ? ROWS : COLS,
  localparam int LANE_W    = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int OUT_AW    = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output logic                    done,
  input  logic                    ldEn,
  input  logic                    ldSide,
  input  logic [LANE_W-1:0]       ldLane,
  input  logic [MEM_AW-1:0]       ldAddr,
  input  logic signed [W-1:0]     ldData,
  input  logic [OUT_AW-1:0]       resAddr,
  output logic signed [ACC_W-1:0] resData
);

  // R1: inner dimensions must agree
  if (TOP_DEPTH != LEFT_DEPTH) begin : g_depthMismatch
    $error("systolic_mm: top and left operand depths differ");
  end

  mmStrobe_t         ctrlStb;
  logic [STEP_W-1:0] stepCnt;

  systolic_mm_ctrl #(
    .LAST_STEP(LAST_STEP), .STEP_W(STEP_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(ctrlStb), .stepCnt(stepCnt), .done(done)
  );

  systolic_mm_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .W(W), .ACC_W(ACC_W),
    .MEM_AW(MEM_AW), .IDX_W(IDX_W), .STEP_W(STEP_W),
    .LANE_W(LANE_W), .OUT_AW(OUT_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .stepCnt(stepCnt),
    .ldEn(ldEn), .ldSide(ldSide), .ldLane(ldLane),
    .ldAddr(ldAddr), .ldData(ldData),
    .resAddr(resAddr), .resData(resData)
  );

endmodule

// File: rtl/systolic_mm_sva.sv
module systolic_mm_sva #(
  parameter int LAT    = 12,
  parameter int OUT_AW = 4,
  parameter int ACC_W  = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              writeStb,
  input logic [OUT_AW-1:0] resAddr,
  input logic [ACC_W-1:0]  resData
);

  logic        running;
  logic [15:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cyc     <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cyc     <= '0;
      end
    end else begin
      cyc <= cyc + 1'b1;
      if (done) running <= 1'b0;
    end
  end

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (running && cyc == 16'(LAT)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_copy_then_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    writeStb |=> done);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> (!$stable(resAddr) || $stable(resData)));

endmodule

bind systolic_mm systolic_mm_sva #(
  .LAT(DEPTH + ROWS + COLS), .OUT_AW(OUT_AW), .ACC_W(ACC_W)
) sva_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .writeStb(ctrlStb.writeOut), .resAddr(resAddr), .resData(resData)
);

// File: tb/systolic_mm_tb.sv
module systolic_mm_tb_top;

  localparam int R   = 3;
  localparam int C   = 4;
  localparam int D   = 5;
  localparam int LAT = D + R + C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        done;
  logic        ldEn = 1'b0;
  logic        ldSide = 1'b0;
  logic [1:0]  ldLane = '0;
  logic [2:0]  ldAddr = '0;
  logic [7:0]  ldData = '0;
  logic [3:0]  resAddr = '0;
  logic [18:0] resData;

  int checks = 0;
  int fails  = 0;
  int since  = -1;
  int A [R][D];
  int B [D][C];

  always #2 clk = ~clk;

  systolic_mm #(.ROWS(R), .COLS(C), .TOP_DEPTH(D), .LEFT_DEPTH(D), .W(8)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .ldEn(ldEn), .ldSide(ldSide), .ldLane(ldLane), .ldAddr(ldAddr),
    .ldData(ldData), .resAddr(resAddr), .resData(resData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of run timing: cycles since an accepted start
  always @(posedge clk) begin
    if (!rstN) since = -1;
    else if (since < 0) begin
      if (start) since = 0;
    end else if (since == LAT) since = -1;
    else since = since + 1;
  end

  // R5 / R4: done compared with the model on every clock
  always @(negedge clk) begin
    if (rstN) chk(done === (since == LAT), "R5/R4 done timing", longint'(done), longint'(since == LAT));
  end

  function automatic longint refRes(int r, int c);
    longint s = 0;
    for (int k = 0; k < D; k++) s += longint'(A[r][k]) * longint'(B[k][c]);
    return s;
  endfunction

  task automatic loadAll();
    for (int r = 0; r < R; r++)
      for (int k = 0; k < D; k++) begin
        @(negedge clk);
        ldEn = 1'b1; ldSide = 1'b0; ldLane = 2'(r); ldAddr = 3'(k); ldData = 8'(A[r][k]);
      end
    for (int c = 0; c < C; c++)
      for (int k = 0; k < D; k++) begin
        @(negedge clk);
        ldEn = 1'b1; ldSide = 1'b1; ldLane = 2'(c); ldAddr = 3'(k); ldData = 8'(B[k][c]);
      end
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic runOnce(input bit midStart);
    int guard = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStart) begin
      repeat (4) @(negedge clk);
      start = 1'b1;               // R4: must be ignored
      @(negedge clk); start = 1'b0;
    end
    while (since != LAT && guard < 1000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 1000, "R5 done reached", guard, 0);
  endtask

  task automatic checkAll(input string req);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        resAddr = 4'(r * C + c);
        #1;
        chk($signed(resData) == refRes(r, c), req, longint'($signed(resData)), refRes(r, c));
      end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R7 results zero, done low
    chk(done === 1'b0, "R7 reset done", longint'(done), 0);
    for (int i = 0; i < R * C; i++) begin
      resAddr = 4'(i); #1;
      chk(resData === '0, "R7 reset result", longint'(resData), 0);
    end
    @(negedge clk); rstN = 1'b1;

    // pattern 1: small mixed-sign values (R2, R3, R9)
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = r + k + 1;
    for (int k = 0; k < D; k++) for (int c = 0; c < C; c++) B[k][c] = c - k;
    loadAll();
    runOnce(1'b0);
    checkAll("R3 pattern1");

    // R7: results held while idle and across operand rewrites
    repeat (20) @(negedge clk);
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = 0;
    loadAll();
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = r + k + 1;
    checkAll("R7 hold after operand write");
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = 0;

    // pattern 2: extreme operands (R3 sign handling), clears prior sums (R6)
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = ((r + k) % 2) ? -128 : 127;
    for (int k = 0; k < D; k++) for (int c = 0; c < C; c++) B[k][c] = ((k + c) % 2) ? -128 : 127;
    loadAll();
    runOnce(1'b0);
    checkAll("R6/R3 extremes");
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = -128;
    for (int k = 0; k < D; k++) for (int c = 0; c < C; c++) B[k][c] = -128;
    loadAll();
    runOnce(1'b0);
    checkAll("R3 max magnitude");

    // pattern 3: only the last inner element nonzero (R1)
    for (int r = 0; r < R; r++) for (int k = 0; k < D; k++) A[r][k] = (k == D - 1) ? r + 2 : 0;
    for (int k = 0; k < D; k++) for (int c = 0; c < C; c++) B[k][c] = (k == D - 1) ? -(c + 3) : 0;
    loadAll();
    runOnce(1'b0);
    checkAll("R1 last inner term");

    // rerun without reload and with a mid-run start (R8, R4, R6)
    runOnce(1'b1);
    checkAll("R8/R4 rerun");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule